// File: doc/BRIEF.md
# Handshaked Warm Reset Sequencer

This block orders the steps of a warm reset for a system-on-chip. A warm reset starts when any of seven sources requests one: the external reset pin, fabric logic, software, two processor watchdogs or two peripheral watchdogs. Before any reset line moves, the block warns up to five agents in turn, each enabled on its own. The agents are the memory controller (which is asked to enter self-refresh), two clock-producing managers, fabric logic, and a trace bus master (which is asked to drain its bus traffic). Each warning is a request/acknowledge pair with its own bounded wait. An agent that stays silent gets a timeout bit in the status word, and the sequence moves on.

Once the handshakes are done, the block asserts the clock-domain reset and the other warm resets together, and pulls the external reset pin low for a programmed number of cycles. The clock-domain reset is released first. The other resets follow after a programmed delay, which is clamped to the range 17..255. A 32-bit status word records reset causes and handshake timeouts until software clears them by writing a mask.

Top module: `warmRstSeq`

## Requirements
- R1: While idle, a high bit on `warmSrc` starts a sequence and sets the matching cause bit in `status`. The source-to-bit mapping is: bit 0 pin → 8, bit 1 fabric → 9, bit 2 software → 10, bits 3..4 processor watchdogs → 12..13, bits 5..6 peripheral watchdogs → 14..15.
- R2: Handshakes are raised on `hsReq` in ascending index order: 0 self-refresh, 1 first clock manager, 2 second clock manager, 3 fabric, 4 trace stall. A handshake whose `cfgHsEn` bit is 0 is never raised. Skipping it costs no cycle.
- R3: If `hsAck[i]` stays low for HS_LIMIT cycles after `hsReq[i]` rises, status bit 24+i is set and the next handshake starts.
- R4: `clkDomRst` does not rise until every enabled handshake request has been raised. All raised requests stay high until the assertion phase ends.
- R5: `rstPinN` is low for exactly `cfgPinCount` cycles, and a count of 0 leaves it high. Both resets stay asserted for max(`cfgPinCount`, 1) cycles.
- R6: `clkDomRst` falls first. `otherRst` falls D cycles later, where D is `cfgRelDelay` clamped to 17..255.
- R7: When `clrWe` is high, the `status` bits set in `clrMask` are cleared. A cause or timeout that arrives in the same cycle as its clear leaves the bit set.
- R8: Warm sources that arrive while `busy` is high are recorded in `status` but do not start a second sequence.
- R9: `coldCause[4:0]` sets status bits 0..4, and `dbgCause[1:0]` sets status bits 18..19. Neither starts a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset of the sequencer |
| warmSrc | input | 7 | Warm reset requests (mapping in R1) |
| coldCause | input | 5 | Cold reset cause flags, status only |
| dbgCause | input | 2 | Debug reset cause flags, status only |
| cfgHsEn | input | 5 | Per-handshake enables |
| cfgPinCount | input | 20 | Cycles to hold the external pin low |
| cfgRelDelay | input | 9 | Cycles between the two releases, before clamping |
| hsAck | input | 5 | Handshake acknowledges |
| clrWe | input | 1 | Status clear strobe |
| clrMask | input | 32 | Bits of status to clear |
| hsReq | output | 5 | Handshake requests |
| clkDomRst | output | 1 | Clock-domain warm reset, active high |
| otherRst | output | 1 | All other warm resets, active high |
| rstPinN | output | 1 | External reset pin drive, active low |
| busy | output | 1 | A sequence is in progress |
| status | output | 32 | Cause and timeout flags |

## Verification
The hardest states to reach are a timeout on one agent while its neighbours answer, and a second warm request that lands in the middle of a running sequence. The bench models every agent, and for each agent it draws at random whether that agent answers after a chosen latency or never answers. This puts timeouts at any position in the chain. It also fires a second source a few cycles after the first, while handshakes are still pending. Directed runs cover the clamp edges of the release delay, a pin count of zero, a long pin count, and a clear that coincides with a cause.

// File: rtl/warmRstPkg.sv
package warmRstPkg;
  localparam int NUM_HS   = 5;
  localparam int NUM_SRC  = 7;
  localparam int NUM_COLD = 5;
  localparam int NUM_DBG  = 2;
  localparam int STAT_W   = 32;
  localparam int PIN_W    = 20;
  localparam int DLY_W    = 9;
  localparam int CNT_W    = PIN_W;
  localparam int DLY_MIN  = 17;
  localparam int DLY_MAX  = 255;
  localparam int COLD_BASE = 0;
  localparam int DBG_BASE  = 18;
  localparam int TO_BASE   = 24;
  localparam int SRC_BIT [NUM_SRC] = '{8, 9, 10, 12, 13, 14, 15};

  typedef enum logic [1:0] {S_IDLE, S_HS, S_ASSERT, S_REL} seqState_t;

  typedef struct packed {
    logic              loadPin;
    logic              loadDly;
    logic              cntDec;
    logic [NUM_HS-1:0] toSet;
  } seqStrobe_t;

  function automatic logic [CNT_W-1:0] clampDly(input logic [DLY_W-1:0] d);
    if (int'(d) < DLY_MIN) return CNT_W'(DLY_MIN);
    if (int'(d) > DLY_MAX) return CNT_W'(DLY_MAX);
    return CNT_W'(d);
  endfunction
endpackage

// File: rtl/warmRstCtrl.sv
module warmRstCtrl
  import warmRstPkg::*;
#(
  parameter int HS_LIMIT = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_HS-1:0]  cfgEn,
  input  logic               cfgPinZero,
  input  logic [NUM_HS-1:0]  hsAck,
  input  logic               cntLast,
  output seqStrobe_t         strb,
  output logic [NUM_HS-1:0]  hsReq,
  output logic               rstClk,
  output logic               rstOther,
  output logic               pinN,
  output logic               busy
);
  localparam int IDX_W = $clog2(NUM_HS + 1);
  localparam int TMR_W = $clog2(HS_LIMIT + 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(HS_LIMIT - 1);

  seqState_t         state;
  logic [IDX_W-1:0]  idx;
  logic [TMR_W-1:0]  timer;
  logic [NUM_HS-1:0] enSnap;

  logic [IDX_W-1:0]  startIdx;
  logic [IDX_W-1:0]  nxtIdx;
  logic              nxtFound;
  logic [NUM_HS-1:0] scanEn;
  logic              curAck;
  logic              expired;
  logic              hsDone;
  logic              advance;

  // first enabled handshake at or after a start index
  always_comb begin
    nxtFound = 1'b0;
    nxtIdx   = '0;
    for (int i = 0; i < NUM_HS; i++) begin
      if (!nxtFound && (i >= int'(startIdx)) && scanEn[i]) begin
        nxtFound = 1'b1;
        nxtIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    startIdx = (state == S_IDLE) ? '0 : idx + IDX_W'(1);
    scanEn   = (state == S_IDLE) ? cfgEn : enSnap;
    curAck   = 1'b0;
    for (int i = 0; i < NUM_HS; i++) begin
      if (int'(idx) == i) curAck = hsAck[i];
    end
    expired  = (state == S_HS) && !curAck && (timer == TMR_END);
    hsDone   = (state == S_HS) && (curAck || timer == TMR_END);
    advance  = ((state == S_IDLE) && (|srcReq)) || hsDone;
    busy     = (state != S_IDLE);
  end

  always_comb begin
    strb         = '0;
    strb.loadPin = advance && !nxtFound;
    strb.loadDly = (state == S_ASSERT) && cntLast;
    strb.cntDec  = ((state == S_ASSERT) || (state == S_REL)) && !cntLast;
    for (int i = 0; i < NUM_HS; i++) begin
      strb.toSet[i] = expired && (int'(idx) == i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      timer    <= '0;
      enSnap   <= '0;
      hsReq    <= '0;
      rstClk   <= 1'b0;
      rstOther <= 1'b0;
      pinN     <= 1'b1;
    end else begin
      if ((state == S_IDLE) && (|srcReq)) enSnap <= cfgEn;
      if (advance) begin
        if (nxtFound) begin
          state         <= S_HS;
          idx           <= nxtIdx;
          hsReq[nxtIdx] <= 1'b1;
          timer         <= '0;
        end else begin
          state    <= S_ASSERT;
          rstClk   <= 1'b1;
          rstOther <= 1'b1;
          pinN     <= cfgPinZero;
        end
      end else begin
        case (state)
          S_HS:     timer <= timer + TMR_W'(1);
          S_ASSERT: if (cntLast) begin
                      state  <= S_REL;
                      rstClk <= 1'b0;
                      pinN   <= 1'b1;
                      hsReq  <= '0;
                    end
          S_REL:    if (cntLast) begin
                      state    <= S_IDLE;
                      rstOther <= 1'b0;
                    end
          default:  ;
        endcase
      end
    end
  end

  // R4: warm reset only after every enabled agent has been warned
  p_hs_before_rst_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstClk) |-> ((hsReq & enSnap) == enSnap));
  // R3: a handshake never waits past its limit
  p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HS) |-> (int'(timer) < HS_LIMIT));
  // R5: the pin is only driven inside the reset window
  p_pin_inside_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pinN |-> (rstClk && rstOther));
  // R6: the clock-domain reset is already released when the others release
  p_clk_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOther) |-> (!rstClk && !$past(rstClk)));
  // R8: once asserting, the sequence runs on to release without restarting
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ASSERT) |=> (state == S_ASSERT || state == S_REL));
endmodule

// File: rtl/warmRstDp.sv
module warmRstDp
  import warmRstPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic [PIN_W-1:0]    cfgPinCount,
  input  logic [DLY_W-1:0]    cfgRelDelay,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic [NUM_COLD-1:0] coldCause,
  input  logic [NUM_DBG-1:0]  dbgCause,
  input  logic                clrWe,
  input  logic [STAT_W-1:0]   clrMask,
  output logic                cntLast,
  output logic [STAT_W-1:0]   status
);
  logic [CNT_W-1:0]  cnt;
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;

  always_comb begin
    setVec = '0;
    for (int i = 0; i < NUM_SRC; i++)  setVec[SRC_BIT[i]]   = srcReq[i];
    for (int i = 0; i < NUM_COLD; i++) setVec[COLD_BASE + i] = coldCause[i];
    for (int i = 0; i < NUM_DBG; i++)  setVec[DBG_BASE + i]  = dbgCause[i];
    for (int i = 0; i < NUM_HS; i++)   setVec[TO_BASE + i]   = strb.toSet[i];
    clrVec  = clrWe ? clrMask : '0;
    cntLast = (cnt <= CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.loadPin) cnt <= CNT_W'(cfgPinCount);
    else if (strb.loadDly) cnt <= clampDly(cfgRelDelay);
    else if (strb.cntDec)  cnt <= cnt - CNT_W'(1);
  end

  // R7: a set always survives a clear in the same cycle
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((status & $past(setVec)) == $past(setVec)));
  // R6: the release delay lands inside the legal window
  p_delay_clamped_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDly |=> ((int'(cnt) >= DLY_MIN) && (int'(cnt) <= DLY_MAX)));
  // R5: loading and counting never overlap
  p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.loadPin, strb.loadDly, strb.cntDec}) <= 1);
endmodule

// File: rtl/warmRstSeq.sv
module warmRstSeq
  import warmRstPkg::*;
#(
  parameter int HS_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [6:0]  warmSrc,
  input  logic [4:0]  coldCause,
  input  logic [1:0]  dbgCause,
  input  logic [4:0]  cfgHsEn,
  input  logic [19:0] cfgPinCount,
  input  logic [8:0]  cfgRelDelay,
  input  logic [4:0]  hsAck,
  input  logic        clrWe,
  input  logic [31:0] clrMask,
  output logic [4:0]  hsReq,
  output logic        clkDomRst,
  output logic        otherRst,
  output logic        rstPinN,
  output logic        busy,
  output logic [31:0] status
);
  seqStrobe_t strb;
  logic       cntLast;
  logic       pinZero;

  assign pinZero = (cfgPinCount == '0);

  warmRstCtrl #(.HS_LIMIT(HS_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcReq(warmSrc), .cfgEn(cfgHsEn),
    .cfgPinZero(pinZero), .hsAck(hsAck), .cntLast(cntLast), .strb(strb),
    .hsReq(hsReq), .rstClk(clkDomRst), .rstOther(otherRst), .pinN(rstPinN),
    .busy(busy)
  );

  warmRstDp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgPinCount(cfgPinCount),
    .cfgRelDelay(cfgRelDelay), .srcReq(warmSrc), .coldCause(coldCause),
    .dbgCause(dbgCause), .clrWe(clrWe), .clrMask(clrMask),
    .cntLast(cntLast), .status(status)
  );
endmodule

// File: tb/warmRstSeq_bench.sv
`timescale 1ns/1ps
module warmRstSeq_bench;
  localparam int LIMIT = 32;

  logic clk = 0;
  logic rstN = 0;
  logic [6:0]  warmSrc = '0;
  logic [4:0]  coldCause = '0;
  logic [1:0]  dbgCause = '0;
  logic [4:0]  cfgHsEn = '0;
  logic [19:0] cfgPinCount = '0;
  logic [8:0]  cfgRelDelay = '0;
  logic [4:0]  hsAck = '0;
  logic        clrWe = 0;
  logic [31:0] clrMask = '0;
  logic [4:0]  hsReq;
  logic        clkDomRst, otherRst, rstPinN, busy;
  logic [31:0] status;

  int nChecks = 0;
  int nFail = 0;

  // agent model controls
  logic [4:0] deafMask = '0;
  int ackLat = 1;
  int ackCnt [5];

  // monitor results
  int clkHigh, pinLow, gapCyc, clkRises, ordN;
  int ordLog [8];
  bit allReqAtRise;
  logic [4:0] prevReq = '0;
  logic prevClk = 0;

  always #2.5 clk = ~clk;

  warmRstSeq #(.HS_LIMIT(LIMIT)) u_warmRstSeq (
    .clk(clk), .rstN(rstN), .warmSrc(warmSrc), .coldCause(coldCause),
    .dbgCause(dbgCause), .cfgHsEn(cfgHsEn), .cfgPinCount(cfgPinCount),
    .cfgRelDelay(cfgRelDelay), .hsAck(hsAck), .clrWe(clrWe), .clrMask(clrMask),
    .hsReq(hsReq), .clkDomRst(clkDomRst), .otherRst(otherRst),
    .rstPinN(rstPinN), .busy(busy), .status(status)
  );

  function automatic int clampExp(input int d);
    if (d < 17) return 17;
    if (d > 255) return 255;
    return d;
  endfunction

  function automatic logic [31:0] srcBit(input int s);
    int pos [7] = '{8, 9, 10, 12, 13, 14, 15};
    return 32'd1 << pos[s];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // handshake agents
  initial begin
    for (int i = 0; i < 5; i++) ackCnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
        if (hsReq[i] && !deafMask[i]) begin
          ackCnt[i]++;
          if (ackCnt[i] >= ackLat) hsAck[i] = 1'b1;
        end else if (!hsReq[i]) begin
          ackCnt[i] = 0;
          hsAck[i]  = 1'b0;
        end
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (clkDomRst) clkHigh++;
      if (!rstPinN) pinLow++;
      if (otherRst && !clkDomRst) gapCyc++;
      if (clkDomRst && !prevClk) begin
        clkRises++;
        if ((hsReq & cfgHsEn) != cfgHsEn) allReqAtRise = 0;
      end
      for (int i = 0; i < 5; i++) begin
        if (hsReq[i] && !prevReq[i] && ordN < 8) begin
          ordLog[ordN] = i;
          ordN++;
        end
      end
      prevReq = hsReq;
      prevClk = clkDomRst;
    end
  end

  task automatic clearAll();
    @(negedge clk);
    clrWe = 1; clrMask = '1;
    @(negedge clk);
    clrWe = 0; clrMask = '0;
  endtask

  task automatic runSeq(input logic [4:0] en, input int pin, input int dly,
                        input logic [4:0] deaf, input int lat, input int src,
                        input int extra);
    logic [31:0] expStat;
    int expOrd [8];
    int expN;
    int waitCyc;
    @(negedge clk);
    cfgHsEn = en; cfgPinCount = 20'(pin); cfgRelDelay = 9'(dly);
    deafMask = deaf; ackLat = lat;
    clkHigh = 0; pinLow = 0; gapCyc = 0; clkRises = 0; ordN = 0;
    allReqAtRise = 1;
    warmSrc = 7'd1 << src;
    @(negedge clk);
    warmSrc = '0;
    if (extra >= 0) begin
      repeat (3) @(negedge clk);
      warmSrc = 7'd1 << extra;
      @(negedge clk);
      warmSrc = '0;
    end
    waitCyc = 0;
    while ((busy || otherRst) && waitCyc < 4000) begin
      @(negedge clk);
      waitCyc++;
    end
    repeat (2) @(negedge clk);
    expN = 0;
    for (int i = 0; i < 5; i++) if (en[i]) begin expOrd[expN] = i; expN++; end
    chk("R2 handshake count", ordN, expN);
    for (int i = 0; i < expN && i < ordN; i++) chk("R2 handshake order", ordLog[i], expOrd[i]);
    chk("R4 all requests raised before reset", allReqAtRise, 1);
    chk("R5 pin low cycles", pinLow, pin);
    chk("R5 reset assert cycles", clkHigh, (pin < 1) ? 1 : pin);
    chk("R6 staged release gap", gapCyc, clampExp(dly));
    chk("R8 single sequence", clkRises, 1);
    expStat = srcBit(src) | (32'(en & deaf) << 24);
    if (extra >= 0) expStat |= srcBit(extra);
    chk("R1 R3 status causes and timeouts", status, expStat);
    clearAll();
    chk("R7 status cleared", status, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset idle outputs", {hsReq, clkDomRst, otherRst, rstPinN, busy}, 9'b000000010);

    // directed: no handshakes, pin count zero, low clamp
    runSeq(5'b00000, 0, 0, 5'b00000, 1, 2, -1);
    // all handshakes, ack fast, clamp edges
    runSeq(5'b11111, 5, 16, 5'b00000, 1, 0, -1);
    runSeq(5'b10101, 3, 17, 5'b00000, 2, 1, -1);
    runSeq(5'b01010, 1, 255, 5'b00000, 3, 3, -1);
    runSeq(5'b00001, 2, 256, 5'b00000, 1, 4, -1);
    runSeq(5'b11000, 1000, 511, 5'b00000, 1, 5, -1);
    // R3: all agents silent
    runSeq(5'b11111, 4, 20, 5'b11111, 1, 6, -1);
    // R3: one silent agent in the middle
    runSeq(5'b11111, 2, 30, 5'b00100, 4, 2, -1);
    // R8: second request mid-sequence
    runSeq(5'b00110, 6, 40, 5'b00000, 5, 0, 2);

    // R7/R9: cold and debug causes, set beats clear, partial clear
    @(negedge clk);
    coldCause = 5'b00100; clrWe = 1; clrMask = '1;
    @(negedge clk);
    coldCause = '0; clrWe = 0; clrMask = '0;
    chk("R7 set wins over clear", status, 32'h4);
    chk("R9 cold cause does not start sequence", busy, 0);
    coldCause = 5'b10011; dbgCause = 2'b11;
    @(negedge clk);
    coldCause = '0; dbgCause = '0;
    chk("R9 cold and debug bits", status, 32'h000C_0017);
    clrWe = 1; clrMask = 32'h0004_0001;
    @(negedge clk);
    clrWe = 0; clrMask = '0;
    chk("R7 partial clear", status, 32'h0008_0016);
    clearAll();

    // random runs
    for (int k = 0; k < 30; k++) begin
      logic [4:0] en, deaf;
      int pin, dly, lat, src, extra;
      en   = 5'($urandom);
      deaf = 5'($urandom) & 5'($urandom);
      pin  = $urandom_range(0, 40);
      dly  = $urandom_range(0, 511);
      lat  = $urandom_range(1, 20);
      src  = $urandom_range(0, 6);
      extra = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : -1;
      runSeq(en, pin, dly, deaf, lat, src, extra);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule